// File: doc/BRIEF.md
# Memory Test Access Port with Identification Register

This block is the boundary test port of a memory device. A sixteen-state controller, clocked by the test clock and steered by the mode-select input, moves through the standard data-scan and instruction-scan branches. A three-bit instruction register selects which data register sits between the serial input and the serial output. The choices are a 32-bit identification register, a one-bit bypass register, or a one-bit output-enable control register. The output-enable control gates the device's read-data pins.

The serial output changes on the falling test-clock edge. It is driven only while a shift state is active, and an enable output tells the pad when to drive it. Board test software can read the identification word, bypass the device in a longer chain, or turn the read-data drivers off. None of this disturbs normal memory traffic.

Top module: `mem_test_port`

## Requirements
- R1: With `trst_n` low at a rising `tck` edge, the controller enters Test-Logic-Reset. At that point `tdo_en` is low, `rdata_oe` is high, and the identification instruction (3'b001) is selected.
- R2: Five consecutive rising `tck` edges with `tms` high bring the controller to Test-Logic-Reset from any state. On that transition the identification instruction is reloaded.
- R3: State changes follow the standard sixteen-state diagram on each rising `tck` edge. This includes the path Shift-DR, Exit1-DR, Pause-DR, Exit2-DR and back to Shift-DR, which does not recapture the register.
- R4: With instruction 3'b001, Capture-DR loads the 32-bit word 0x2B496069, which then shifts out least significant bit first. Bits 31..29 hold version 3'b001, bits 28..12 hold device type 17'b01011010010010110, bits 11..1 hold vendor 11'b00000110100, and bit 0 is 1.
- R5: Capture-IR loads 3'b001 into the instruction shift register, so the first two bits shifted out are 1 then 0.
- R6: Instruction 3'b111 selects a one-bit bypass register. It captures 0, so the serial output is the serial input delayed by one shift edge.
- R7: The unused codes 3'b000, 3'b011, 3'b100, 3'b101 and 3'b110 behave exactly like bypass.
- R8: Instruction 3'b010 selects a one-bit output-enable register. Capture-DR loads the present `rdata_oe` value, and Update-DR copies the shifted-in bit to `rdata_oe`.
- R9: `rdata_oe` is set high on every entry into Test-Logic-Reset.
- R10: `tdo` and `tdo_en` change only on the falling `tck` edge. `tdo_en` is high exactly while the controller is in Shift-IR or Shift-DR, and `tdo` reads 0 otherwise.
- R11: The active instruction changes only on the edge leaving Update-IR, or when Test-Logic-Reset is entered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Active-low test reset, sampled on the rising `tck` edge |
| tms | input | 1 | Mode select, steers the controller |
| tdi | input | 1 | Serial data input |
| tdo | output | 1 | Serial data output, updated on the falling edge |
| tdo_en | output | 1 | High when `tdo` must be driven |
| rdata_oe | output | 1 | Enable for the device's read-data drivers |

## Verification
The controller state and all captures, shifts and updates take effect on the rising `tck` edge where the corresponding state is exited. The serial output then presents the new value half a period later, on the falling edge. The bench therefore drives `tms`/`tdi` and samples `tdo`/`tdo_en` just after each falling edge. The bit read there is the one consumed by the next rising edge. `rdata_oe` is read one nanosecond after the rising edge that leaves Update-DR or enters Test-Logic-Reset. The falling-edge timing of `tdo_en` is checked directly by sampling it both after the rising edge that enters Shift-DR and after the falling edge that follows.

// File: rtl/tapx_pkg.sv
// Shared definitions for the memory test port: controller states,
// instruction codes, identification word fields and the next-state function.
// Assumes a 3-bit instruction register; field widths must sum to 32.
package tapx_pkg;

    localparam int IR_W   = 3;
    localparam int VER_W  = 3;
    localparam int DEV_W  = 17;
    localparam int VEND_W = 11;
    localparam int ID_W   = VER_W + DEV_W + VEND_W + 1;

    localparam logic [VER_W-1:0]  ID_VERSION = 3'b001;
    localparam logic [DEV_W-1:0]  ID_DEVICE  = 17'b01011010010010110;
    localparam logic [VEND_W-1:0] ID_VENDOR  = 11'b00000110100;
    localparam logic [ID_W-1:0]   ID_WORD    = {ID_VERSION, ID_DEVICE, ID_VENDOR, 1'b1};

    localparam logic [IR_W-1:0] OP_IDENT  = 3'b001;
    localparam logic [IR_W-1:0] OP_OECTL  = 3'b010;
    localparam logic [IR_W-1:0] OP_BYPASS = 3'b111;

    typedef enum logic [3:0] {
        ST_RESET, ST_IDLE,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    // Successor of state s for mode-select value m.
    function automatic tap_state_e tap_next(tap_state_e s, logic m);
        case (s)
            ST_RESET:  return m ? ST_RESET  : ST_IDLE;
            ST_IDLE:   return m ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: return m ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: return m ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  return m ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: return m ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: return m ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: return m ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: return m ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: return m ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: return m ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  return m ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: return m ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: return m ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: return m ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: return m ? ST_SEL_DR : ST_IDLE;
            default:   return ST_RESET;
        endcase
    endfunction

endpackage

// File: rtl/tapx_ctrl.sv
// Sixteen-state test port controller. Samples tms on the rising tck edge.
// Assumes trst_n is synchronous to tck; the next state is exported so that
// register blocks can act on the edge that enters Test-Logic-Reset.
module tapx_ctrl
    import tapx_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e st_q,
    output tap_state_e st_nxt
);

    // Next-state lookup, reset forces Test-Logic-Reset.
    always_comb begin
        st_nxt = trst_n ? tap_next(st_q, tms) : ST_RESET;
    end

    // State register.
    always_ff @(posedge tck) begin
        st_q <= st_nxt;
    end

endmodule

// File: rtl/tapx_ir.sv
// Instruction register: a shift stage loaded with a fixed pattern in
// Capture-IR, shifted LSB first, and a held instruction updated in Update-IR.
// Assumes the instruction width is at least two bits.
module tapx_ir
    import tapx_pkg::*;
#(
    parameter int W = IR_W
) (
    input  logic         tck,
    input  logic         trst_n,
    input  tap_state_e   st_q,
    input  tap_state_e   st_nxt,
    input  logic         tdi,
    output logic [W-1:0] ir_shift,
    output logic [W-1:0] ir_q
);

    localparam logic [W-1:0] CAPTURE_PAT = W'(2'b01);

    // Shift stage: capture the fixed pattern, then shift toward bit 0.
    always_ff @(posedge tck) begin
        if (!trst_n) begin
            ir_shift <= '0;
        end else if (st_q == ST_CAP_IR) begin
            ir_shift <= CAPTURE_PAT;
        end else if (st_q == ST_SH_IR) begin
            ir_shift <= {tdi, ir_shift[W-1:1]};
        end
    end

    // Held instruction: identification on reset, shifted value on update.
    always_ff @(posedge tck) begin
        if (!trst_n || st_nxt == ST_RESET) begin
            ir_q <= W'(OP_IDENT);
        end else if (st_q == ST_UPD_IR) begin
            ir_q <= ir_shift;
        end
    end

endmodule

// File: rtl/tapx_dr.sv
// Data registers: 32-bit identification, 1-bit bypass and 1-bit
// output-enable control, chosen by the held instruction. Unused codes fall
// back to bypass. Assumes the instruction is stable through a data scan.
module tapx_dr
    import tapx_pkg::*;
#(
    parameter int W = IR_W
) (
    input  logic         tck,
    input  logic         trst_n,
    input  tap_state_e   st_q,
    input  tap_state_e   st_nxt,
    input  logic [W-1:0] ir_q,
    input  logic         tdi,
    output logic         dr_out,
    output logic         rdata_oe
);

    logic [ID_W-1:0] id_sh;
    logic            byp_sh;
    logic            oe_sh;
    logic            sel_id;
    logic            sel_oe;

    // Register selection from the held instruction.
    always_comb begin
        sel_id = (ir_q == W'(OP_IDENT));
        sel_oe = (ir_q == W'(OP_OECTL));
    end

    // Identification shift register.
    always_ff @(posedge tck) begin
        if (!trst_n) begin
            id_sh <= '0;
        end else if (st_q == ST_CAP_DR && sel_id) begin
            id_sh <= ID_WORD;
        end else if (st_q == ST_SH_DR && sel_id) begin
            id_sh <= {tdi, id_sh[ID_W-1:1]};
        end
    end

    // Bypass bit: captures zero, shifts tdi for every other code.
    always_ff @(posedge tck) begin
        if (!trst_n || st_q == ST_CAP_DR) begin
            byp_sh <= 1'b0;
        end else if (st_q == ST_SH_DR && !sel_id && !sel_oe) begin
            byp_sh <= tdi;
        end
    end

    // Output-enable shift bit: captures the live enable.
    always_ff @(posedge tck) begin
        if (!trst_n) begin
            oe_sh <= 1'b0;
        end else if (st_q == ST_CAP_DR && sel_oe) begin
            oe_sh <= rdata_oe;
        end else if (st_q == ST_SH_DR && sel_oe) begin
            oe_sh <= tdi;
        end
    end

    // Live read-data enable: preset on reset entry, loaded on update.
    always_ff @(posedge tck) begin
        if (!trst_n || st_nxt == ST_RESET) begin
            rdata_oe <= 1'b1;
        end else if (st_q == ST_UPD_DR && sel_oe) begin
            rdata_oe <= oe_sh;
        end
    end

    // Serial output of the selected register.
    always_comb begin
        if (sel_id)      dr_out = id_sh[0];
        else if (sel_oe) dr_out = oe_sh;
        else             dr_out = byp_sh;
    end

endmodule

// File: rtl/mem_test_port.sv
// Top of the memory test port. Joins controller, instruction register and
// data registers and retimes the serial output onto the falling tck edge.
// Assumes a free-running tck whenever trst_n is released.
module mem_test_port
    import tapx_pkg::*;
(
    input  logic tck,
    input  logic trst_n,
    input  logic tms,
    input  logic tdi,
    output logic tdo,
    output logic tdo_en,
    output logic rdata_oe
);

    tap_state_e       st_q;
    tap_state_e       st_nxt;
    logic [IR_W-1:0]  ir_shift;
    logic [IR_W-1:0]  ir_q;
    logic             dr_out;

    tapx_ctrl u_ctrl (
        .tck    (tck),
        .trst_n (trst_n),
        .tms    (tms),
        .st_q   (st_q),
        .st_nxt (st_nxt)
    );

    tapx_ir #(.W(IR_W)) u_ir (
        .tck      (tck),
        .trst_n   (trst_n),
        .st_q     (st_q),
        .st_nxt   (st_nxt),
        .tdi      (tdi),
        .ir_shift (ir_shift),
        .ir_q     (ir_q)
    );

    tapx_dr #(.W(IR_W)) u_dr (
        .tck      (tck),
        .trst_n   (trst_n),
        .st_q     (st_q),
        .st_nxt   (st_nxt),
        .ir_q     (ir_q),
        .tdi      (tdi),
        .dr_out   (dr_out),
        .rdata_oe (rdata_oe)
    );

    // Falling-edge output stage: drive only in the two shift states.
    always_ff @(negedge tck) begin
        if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            tdo_en <= (st_q == ST_SH_IR) || (st_q == ST_SH_DR);
            if (st_q == ST_SH_IR)      tdo <= ir_shift[0];
            else if (st_q == ST_SH_DR) tdo <= dr_out;
            else                       tdo <= 1'b0;
        end
    end

endmodule

// File: rtl/mem_test_port_chk.sv
// Property checker for the memory test port, bound into the top module.
// Counts consecutive tms-high edges itself to check the five-edge reset.
module mem_test_port_chk
    import tapx_pkg::*;
(
    input  logic            tck,
    input  logic            trst_n,
    input  logic            tms,
    input  tap_state_e      st_q,
    input  tap_state_e      st_nxt,
    input  logic [IR_W-1:0] ir_shift,
    input  logic [IR_W-1:0] ir_q,
    input  logic            tdo_en,
    input  logic            rdata_oe
);

    logic [2:0] ones_cnt;

    // Saturating count of consecutive tms-high edges since reset.
    always_ff @(posedge tck) begin
        if (!trst_n)       ones_cnt <= '0;
        else if (!tms)     ones_cnt <= '0;
        else if (ones_cnt != 3'd5) ones_cnt <= ones_cnt + 3'd1;
    end

    assert_reset_entry_R1: assert property (@(posedge tck)
        !trst_n |=> (st_q == ST_RESET && rdata_oe && ir_q == OP_IDENT));

    assert_five_ones_R2: assert property (@(posedge tck) disable iff (!trst_n)
        ones_cnt == 3'd5 |-> st_q == ST_RESET);

    assert_shift_hold_R3: assert property (@(posedge tck) disable iff (!trst_n)
        (st_q == ST_SH_DR && !tms) |=> st_q == ST_SH_DR);

    assert_update_to_idle_R3: assert property (@(posedge tck) disable iff (!trst_n)
        (st_q == ST_UPD_IR && !tms) |=> st_q == ST_IDLE);

    assert_ir_capture_R5: assert property (@(posedge tck) disable iff (!trst_n)
        st_q == ST_CAP_IR |=> ir_shift[1:0] == 2'b01);

    assert_oe_in_reset_R9: assert property (@(posedge tck) disable iff (!trst_n)
        st_q == ST_RESET |-> rdata_oe);

    assert_tdo_enable_R10: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_en == (st_q == ST_SH_DR || st_q == ST_SH_IR));

    assert_ir_held_R11: assert property (@(posedge tck) disable iff (!trst_n)
        (st_q != ST_UPD_IR && st_nxt != ST_RESET) |=> $stable(ir_q));

endmodule

bind mem_test_port mem_test_port_chk u_chk (
    .tck      (tck),
    .trst_n   (trst_n),
    .tms      (tms),
    .st_q     (st_q),
    .st_nxt   (st_nxt),
    .ir_shift (ir_shift),
    .ir_q     (ir_q),
    .tdo_en   (tdo_en),
    .rdata_oe (rdata_oe)
);

// File: tb/mem_test_port_test.sv
// Self-checking bench for the memory test port: directed corner cases plus
// seeded random walks and random unused instruction codes.
module mem_test_port_test;

    logic tck = 1'b0;
    logic trst_n = 1'b0;
    logic tms = 1'b1;
    logic tdi = 1'b0;
    logic tdo;
    logic tdo_en;
    logic rdata_oe;

    int n_chk = 0;
    int n_fail = 0;

    mem_test_port uut (
        .tck      (tck),
        .trst_n   (trst_n),
        .tms      (tms),
        .tdi      (tdi),
        .tdo      (tdo),
        .tdo_en   (tdo_en),
        .rdata_oe (rdata_oe)
    );

    always #5 tck = ~tck;

    // Expected identification word built from its fields (R4).
    function automatic logic [31:0] exp_ident();
        return {3'b001, 17'b01011010010010110, 11'b00000110100, 1'b1};
    endfunction

    // Expected bypass output: captured zero, then input delayed one edge.
    function automatic logic [31:0] exp_bypass(logic [31:0] din);
        return {din[30:0], 1'b0};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One tck cycle: sample outputs after the falling edge, then drive inputs.
    task automatic step(input logic m, input logic d, output logic o, output logic e);
        @(negedge tck);
        #1;
        o = tdo;
        e = tdo_en;
        tms = m;
        tdi = d;
        @(posedge tck);
    endtask

    task automatic go(input logic m);
        logic o, e;
        step(m, 1'b0, o, e);
    endtask

    // Five tms-high edges, then into Run-Test/Idle.
    task automatic reset_tap();
        for (int i = 0; i < 5; i++) go(1'b1);
        go(1'b0);
    endtask

    // Data scan of n bits from Run-Test/Idle back to Run-Test/Idle.
    task automatic shift_dr(input int n, input logic [31:0] din,
                            output logic [31:0] dout, output logic en_ok);
        logic o, e;
        dout = '0;
        en_ok = 1'b1;
        go(1'b1);
        go(1'b0);
        go(1'b0);
        for (int i = 0; i < n; i++) begin
            step(i == n - 1, din[i], o, e);
            dout[i] = o;
            if (!e) en_ok = 1'b0;
        end
        go(1'b1);
        go(1'b0);
        #1;
    endtask

    // Instruction scan from Run-Test/Idle back to Run-Test/Idle.
    task automatic shift_ir(input logic [2:0] code, output logic [2:0] cap);
        logic o, e;
        go(1'b1);
        go(1'b1);
        go(1'b0);
        go(1'b0);
        for (int i = 0; i < 3; i++) begin
            step(i == 2, code[i], o, e);
            cap[i] = o;
        end
        go(1'b1);
        go(1'b0);
        #1;
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] dout, din;
        logic        en_ok, o, e;
        logic [2:0]  cap;
        logic [2:0]  code;
        int          unused;
        unused = $urandom(32'd1149);

        // R1: reset state.
        repeat (3) @(posedge tck);
        #1;
        check("R1 tdo_en", {31'b0, tdo_en}, 32'd0);
        check("R1 rdata_oe", {31'b0, rdata_oe}, 32'd1);
        @(negedge tck);
        trst_n = 1'b1;
        tms = 1'b0;
        @(posedge tck);

        // R1 and R4: identification is selected after reset.
        shift_dr(32, 32'hFFFF_FFFF, dout, en_ok);
        check("R4 ident word", dout, exp_ident());
        check("R10 enable in shift", {31'b0, en_ok}, 32'd1);

        // R10: enable appears on the falling edge, not the rising one.
        go(1'b1);
        go(1'b0);
        go(1'b0);
        #1;
        check("R10 enable before fall", {31'b0, tdo_en}, 32'd0);
        @(negedge tck);
        #1;
        check("R10 enable after fall", {31'b0, tdo_en}, 32'd1);
        go(1'b1);
        go(1'b1);
        go(1'b0);
        #1;
        check("R10 idle output", {30'b0, tdo_en, tdo}, 32'd0);

        // R3: shift, pause and resume without recapture.
        go(1'b1);
        go(1'b0);
        go(1'b0);
        dout = '0;
        for (int i = 0; i < 16; i++) begin
            step(i == 15, 1'b0, o, e);
            dout[i] = o;
        end
        go(1'b0);
        step(1'b0, 1'b0, o, e);
        check("R3 pause disables tdo", {31'b0, e}, 32'd0);
        step(1'b1, 1'b0, o, e);
        go(1'b0);
        for (int i = 16; i < 32; i++) begin
            step(i == 31, 1'b0, o, e);
            dout[i] = o;
        end
        go(1'b1);
        go(1'b0);
        check("R3 pause resume", dout, exp_ident());

        // R5 and R6: capture pattern, then bypass.
        shift_ir(3'b111, cap);
        check("R5 ir capture", {29'b0, cap}, 32'd1);
        din = 32'($urandom) & 32'h0000_FFFF;
        shift_dr(16, din, dout, en_ok);
        check("R6 bypass", dout & 32'hFFFF, exp_bypass(din) & 32'hFFFF);

        // R7: unused codes behave as bypass.
        for (int k = 0; k < 20; k++) begin
            case ($urandom_range(0, 4))
                0: code = 3'b000;
                1: code = 3'b011;
                2: code = 3'b100;
                3: code = 3'b101;
                default: code = 3'b110;
            endcase
            shift_ir(code, cap);
            din = 32'($urandom) & 32'h0000_00FF;
            shift_dr(8, din, dout, en_ok);
            check($sformatf("R7 code %0d", code), dout & 32'hFF, exp_bypass(din) & 32'hFF);
        end

        // R8 and R11: output-enable register, instruction held across scans.
        shift_ir(3'b010, cap);
        shift_dr(1, 32'd0, dout, en_ok);
        check("R8 capture live oe", dout, 32'd1);
        check("R8 oe cleared", {31'b0, rdata_oe}, 32'd0);
        shift_dr(1, 32'd1, dout, en_ok);
        check("R11 R8 held instruction capture", dout, 32'd0);
        check("R8 oe set", {31'b0, rdata_oe}, 32'd1);
        shift_dr(1, 32'd0, dout, en_ok);
        check("R8 oe cleared again", {31'b0, rdata_oe}, 32'd0);

        // R9 and R2: mode-select reset restores enable and identification.
        reset_tap();
        check("R9 oe after reset", {31'b0, rdata_oe}, 32'd1);
        shift_dr(32, 32'd0, dout, en_ok);
        check("R2 ident after reset", dout, exp_ident());

        // R2: random walks, then five tms-high edges.
        for (int k = 0; k < 30; k++) begin
            for (int j = 0; j < int'($urandom_range(0, 24)); j++) begin
                step(1'($urandom), 1'($urandom), o, e);
            end
            reset_tap();
            check("R2 R9 oe after walk", {31'b0, rdata_oe}, 32'd1);
            shift_dr(32, 32'($urandom), dout, en_ok);
            check("R2 ident after walk", dout, exp_ident());
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule